// File: doc/BRIEF.md
# Command-Driven Quad-Line Serial Flash Master

This block is a half-duplex serial master for flash devices, driven entirely through a small register file. Software loads a clock divider, a per-device mode byte and up to 128 bits of transmit data. It then writes a command word, and the engine shifts one word across the serial pins. A write word goes out on one line. A read word comes in on one, two or four lines. Each word is addressed to one of four chip selects.

Several words form a frame. The chip select stays asserted from word to word until the programmed number of words has completed, or until software issues an invalidate command. Software learns about progress by polling two status bits: one shows that a word is in flight, the other that the last word has finished.

Top module: `qspi_cmd_engine`

## Requirements
- R1: Registers are selected by `reg_addr`: 0 clock control, 1 device control, 2 command, 3 status, 4..7 data words 0..3 (word 0 least significant). After reset every register reads zero, SCLK is low, no line is driven and every chip-select pin is at its inactive level (high).
- R2: Clock control bit 31 enables SCLK and bits 15:0 hold a divider D. One SCLK period spans D+1 clock cycles, and D=0 behaves as D=1. While bit 31 is clear, a word in flight makes no progress and SCLK does not toggle.
- R3: The command fields are: bits 29:28 chip select, bits 25:19 word length minus one (N up to 128), bits 11:0 frame length minus one. Bits 18:16 hold the code: 1 is a single-line read, 2 a single-line write, 3 a dual read, 7 a quad read and 4 invalidate. Any other code is ignored: it leaves the command register, the status and the pins unchanged. N must be a multiple of the line count.
- R4: Status bit 0 (busy) rises at the clock edge that accepts a word command and stays set for (N/lines)·(D+1) cycles. Status bit 1 (word complete) sets as busy falls, and clears when the next command is accepted.
- R5: A command written while busy is ignored. The command register, the word in flight and its timing are unaffected.
- R6: A write transmits bits N-1..0 of {data3,data2,data1,data0}, most significant first, on IO0. IO0 is enabled only while a write word is busy.
- R7: Read words drive no line. Single reads sample IO1. Dual reads sample {IO1,IO0} and quad reads sample {IO3..IO0}, with the higher-numbered line carrying the more significant bit. The received word lands right-aligned in the data registers, with the upper bits zero.
- R8: Device-control byte n (bits 8n+7:8n) configures chip select n: bit 0 is clock polarity (the SCLK idle level), bit 1 makes the chip select active high, and bit 2 is phase. With phase 0 data is sampled on the leading SCLK edge and changes on the trailing edge. With phase 1 it changes on the leading edge and is sampled on the trailing edge.
- R9: The chip select stays asserted between the words of a frame. It deasserts after the word that completes frame length + 1 words, and the word count restarts at zero.
- R10: An accepted invalidate deasserts the chip select at the next edge and resets the frame word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| sclk | output | 1 | Serial clock |
| cs_pin | output | 4 | Chip-select pins, polarity per device |
| io_out | output | 4 | Serial data out (IO0 used) |
| io_oe | output | 4 | Output enables for the data lines |
| io_in | input | 4 | Serial data in |

## Verification
Busy rises on the clock edge that accepts the command. The bench therefore counts falling edges with busy set, starting just after that edge, and expects exactly (N/lines)·(D+1). Word complete and the received data are read on the first falling edge after busy clears. The chip-select level is checked one falling edge after an invalidate is written. The bench's slave model reacts to SCLK transitions and never to the system clock. Its data therefore changes at least one cycle before the engine samples, and the bench records the SCLK period from the times of the leading edges.

// File: rtl/qspi_cmd_engine.sv
module qspi_cmd_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sclk,
  output logic [3:0]  cs_pin,
  output logic [3:0]  io_out,
  output logic [3:0]  io_oe,
  input  logic [3:0]  io_in
);
  localparam int WMAX = 128;
  localparam int DW   = 16;
  localparam int LW   = $clog2(WMAX);
  localparam int FW   = 12;
  localparam int NCS  = 4;

  logic [31:0]     clk_q, dc_q, cmd_q;
  logic [WMAX-1:0] data_q, tx_sr, rx_sr, rx_next;
  logic            busy, wc, act, frame_on, wr_q, cpol_q, cpha_q;
  logic [1:0]      cs_q, lw_q;
  logic [LW-1:0]   per_cnt, steps_q;
  logic [DW:0]     h_cnt;
  logic [FW-1:0]   fcnt, flen_q;

  wire          cmd_wr  = reg_we && reg_addr == 3'd2;
  wire [2:0]    ncode   = reg_wdata[18:16];
  wire          n_word  = ncode == 3'd1 || ncode == 3'd2 || ncode == 3'd3 || ncode == 3'd7;
  wire          n_inval = ncode == 3'd4;
  wire          accept  = cmd_wr && !busy && (n_word || n_inval);
  wire          start   = accept && n_word;
  wire [1:0]    n_lw    = ncode == 3'd7 ? 2'd2 : (ncode == 3'd3 ? 2'd1 : 2'd0);
  wire [LW-1:0] n_wlm1  = reg_wdata[25:19];
  wire [7:0]    n_dcb   = dc_q[{reg_wdata[29:28], 3'b000} +: 8];

  wire [DW-1:0] div    = clk_q[DW-1:0] == '0 ? DW'(1) : clk_q[DW-1:0];
  wire [DW:0]   per_len = {1'b0, div} + 1'b1;
  wire [DW:0]   lead_len = per_len >> 1;
  wire [DW:0]   trail_len = per_len - lead_len;

  wire tick     = busy && clk_q[31];
  wire lead_ev  = tick && !act && h_cnt == lead_len - 1'b1;
  wire trail_ev = tick && act && h_cnt == trail_len - 1'b1;
  wire last     = trail_ev && per_cnt == steps_q;
  wire samp_ev  = cpha_q ? trail_ev : lead_ev;
  wire shft_ev  = cpha_q ? (lead_ev && per_cnt != '0) : trail_ev;

  always_comb begin
    case (lw_q)
      2'd2:    rx_next = {rx_sr[WMAX-5:0], io_in};
      2'd1:    rx_next = {rx_sr[WMAX-3:0], io_in[1:0]};
      default: rx_next = {rx_sr[WMAX-2:0], io_in[1]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= '0; dc_q <= '0; cmd_q <= '0; data_q <= '0;
      tx_sr <= '0; rx_sr <= '0;
      busy <= 1'b0; wc <= 1'b0; act <= 1'b0; frame_on <= 1'b0;
      wr_q <= 1'b0; cpol_q <= 1'b0; cpha_q <= 1'b0;
      cs_q <= '0; lw_q <= '0; per_cnt <= '0; steps_q <= '0;
      h_cnt <= '0; fcnt <= '0; flen_q <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          3'd0: clk_q <= reg_wdata;
          3'd1: dc_q <= reg_wdata;
          3'd4: data_q[31:0] <= reg_wdata;
          3'd5: data_q[63:32] <= reg_wdata;
          3'd6: data_q[95:64] <= reg_wdata;
          3'd7: data_q[127:96] <= reg_wdata;
          default: ;
        endcase
      end
      if (accept) begin
        cmd_q <= reg_wdata;
        wc <= 1'b0;
      end
      if (start) begin
        busy <= 1'b1;
        act <= 1'b0;
        h_cnt <= '0;
        per_cnt <= '0;
        cs_q <= reg_wdata[29:28];
        lw_q <= n_lw;
        wr_q <= ncode == 3'd2;
        steps_q <= n_wlm1 >> n_lw;
        flen_q <= reg_wdata[FW-1:0];
        cpol_q <= n_dcb[0];
        cpha_q <= n_dcb[2];
        frame_on <= 1'b1;
        tx_sr <= data_q << (LW'(WMAX - 1) - n_wlm1);
        rx_sr <= '0;
      end else if (accept) begin
        frame_on <= 1'b0;
        fcnt <= '0;
      end
      if (tick) begin
        if (lead_ev) begin
          act <= 1'b1;
          h_cnt <= '0;
        end else if (trail_ev) begin
          act <= 1'b0;
          h_cnt <= '0;
          if (!last) per_cnt <= per_cnt + 1'b1;
        end else begin
          h_cnt <= h_cnt + 1'b1;
        end
        if (samp_ev) rx_sr <= rx_next;
        if (shft_ev) tx_sr <= tx_sr << 1;
        if (last) begin
          busy <= 1'b0;
          wc <= 1'b1;
          if (!wr_q) data_q <= samp_ev ? rx_next : rx_sr;
          if (fcnt == flen_q) begin
            frame_on <= 1'b0;
            fcnt <= '0;
          end else begin
            fcnt <= fcnt + 1'b1;
          end
        end
      end
    end
  end

  assign sclk   = act ^ cpol_q;
  assign io_out = {3'b000, busy && wr_q && tx_sr[WMAX-1]};
  assign io_oe  = {3'b000, busy && wr_q};

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_pin[i] = (frame_on && cs_q == 2'(i)) ? dc_q[8*i+1] : ~dc_q[8*i+1];
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = clk_q;
      3'd1:    reg_rdata = dc_q;
      3'd2:    reg_rdata = cmd_q;
      3'd3:    reg_rdata = {30'b0, wc, busy};
      3'd4:    reg_rdata = data_q[31:0];
      3'd5:    reg_rdata = data_q[63:32];
      3'd6:    reg_rdata = data_q[95:64];
      default: reg_rdata = data_q[127:96];
    endcase
  end
endmodule

module qspi_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        busy,
  input logic        wc,
  input logic        sclk,
  input logic [3:0]  cs_pin,
  input logic [3:0]  io_oe,
  input logic [31:0] cmd_q,
  input logic [31:0] dc_q
);
  wire [3:0] idle_cs = ~{dc_q[25], dc_q[17], dc_q[9], dc_q[1]};

  a_r4_busy_wc_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && wc));

  a_r5_busy_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_we && reg_addr == 3'd2 |=> $stable(cmd_q));

  a_r6_drive_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe != 4'b0000 |-> busy);

  a_r2_sclk_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !$past(busy) |-> $stable(sclk));

  a_r10_inval_release: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && reg_we && reg_addr == 3'd2 && reg_wdata[18:16] == 3'd4 |=> cs_pin == idle_cs);

  a_r9_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs_pin ^ idle_cs) <= 1);
endmodule

bind qspi_cmd_engine qspi_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .busy(busy), .wc(wc), .sclk(sclk),
  .cs_pin(cs_pin), .io_oe(io_oe), .cmd_q(cmd_q), .dc_q(dc_q)
);

// File: tb/qspi_cmd_engine_test.sv
`timescale 1ns/1ps
module qspi_cmd_engine_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        sclk;
  logic [3:0]  cs_pin, io_out, io_oe, io_in;

  qspi_cmd_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk),
    .cs_pin(cs_pin), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit done_flag = 0;

  // slave model
  int s_n = 8, s_w = 1, s_shift = 0, s_samp = 0, s_lead = 0, s_idx;
  bit s_cpol = 0, s_cpha = 0, s_arm = 0;
  logic [127:0] s_tx = '0, s_rx = '0, s_tmp;
  logic [3:0] s_cs_seen, s_oe_seen;
  time s_t0, s_t1;

  always @(sclk) begin
    if (s_arm) begin
      if ((sclk != s_cpol) == !s_cpha) begin
        s_rx = {s_rx[126:0], io_out[0]};
        s_samp++;
      end else begin
        s_shift++;
      end
      if (sclk != s_cpol) begin
        if (s_lead == 0) s_t0 = $time;
        else if (s_lead == 1) s_t1 = $time;
        s_lead++;
      end
    end
  end

  always_comb begin
    s_idx = s_cpha ? s_shift - 1 : s_shift;
    io_in = 4'b0000;
    s_tmp = '0;
    if (s_idx >= 0 && s_idx < s_n / s_w) begin
      s_tmp = s_tx >> (s_n - (s_idx + 1) * s_w);
      case (s_w)
        1:       io_in = {2'b00, s_tmp[0], 1'b0};
        2:       io_in = {2'b00, s_tmp[1:0]};
        default: io_in = s_tmp[3:0];
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd_data(output logic [127:0] d);
    logic [31:0] w0, w1, w2, w3;
    rd(3'd4, w0); rd(3'd5, w1); rd(3'd6, w2); rd(3'd7, w3);
    d = {w3, w2, w1, w0};
  endtask

  function automatic logic [31:0] cmd_word(input int cs, input int code, input int n, input int flen);
    return {2'b00, 2'(cs), 2'b00, 7'(n - 1), 3'(code), 4'b0000, 12'(flen)};
  endfunction

  function automatic logic [127:0] mask_of(input int n);
    return (n >= 128) ? '1 : ((128'd1 << n) - 128'd1);
  endfunction

  task automatic run_word(input int cs, input int code, input int n, input int flen,
                          input bit poke, output int busy_cnt);
    s_n = n;
    s_w = (code == 3) ? 2 : ((code == 7) ? 4 : 1);
    s_shift = 0; s_samp = 0; s_lead = 0; s_rx = '0; s_arm = 0;
    s_oe_seen = '0;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = cmd_word(cs, code, n, flen);
    @(posedge clk);
    #1 s_arm = 1; s_cs_seen = cs_pin;
    busy_cnt = 0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      s_oe_seen = s_oe_seen | io_oe;
      if (poke && busy_cnt == 4) begin
        reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h2012_0003;
        busy_cnt++;
      end else begin
        reg_we = 1'b0; reg_addr = 3'd3;
        #1;
        if (reg_rdata[0]) busy_cnt++;
        else break;
      end
    end
    s_arm = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [31:0]  r;
    logic [127:0] d, pat;
    int cnt, div;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), r);
      check(r == 32'h0, $sformatf("R1 reset reg %0d", a), r, 0);
    end
    check(cs_pin == 4'hF && sclk == 1'b0 && io_oe == 4'h0, "R1 reset pins",
          {cs_pin, sclk, io_oe}, {4'hF, 1'b0, 4'h0});

    // mode sweep: R2 R4 R6 R7 R8 R9
    for (int m = 0; m < 4; m++) begin
      bit cpol, cpha;
      cpol = m[1]; cpha = m[0];
      div = 1 + m;
      wr(3'd0, 32'h8000_0000 | div);
      wr(3'd1, 32'(({5'b0, cpha, cpha, cpol}) << (8 * m)));
      s_cpol = cpol; s_cpha = cpha;
      for (int li = 0; li < 3; li++) begin
        int n;
        n = (li == 0) ? 8 : ((li == 1) ? 40 : 128);
        pat = {32'hC3A5_9617 ^ 32'(m * 77), 32'h5E0F_2B81 + 32'(li), 32'h9D27_E4C6, 32'h71B8_0A3F ^ 32'(m)};
        wr(3'd4, pat[31:0]); wr(3'd5, pat[63:32]); wr(3'd6, pat[95:64]); wr(3'd7, pat[127:96]);
        run_word(m, 2, n, 0, 0, cnt);
        check(cnt == n * (div + 1), $sformatf("R4 write busy m%0d n%0d", m, n), cnt, n * (div + 1));
        check((s_rx & mask_of(n)) == (pat & mask_of(n)), $sformatf("R6 write data m%0d n%0d", m, n),
              s_rx & mask_of(n), pat & mask_of(n));
        check(s_oe_seen == 4'b0001, "R6 write drives IO0", s_oe_seen, 1);
        check(s_cs_seen[m] == cpha, "R8 cs polarity active", s_cs_seen[m], cpha);
        check((s_t1 - s_t0) == time'(20 * (div + 1)), "R2 sclk period", s_t1 - s_t0, 20 * (div + 1));
        check(sclk == cpol, "R8 sclk idle level", sclk, cpol);
        check(cs_pin[m] == !cpha, "R9 cs released after last word", cs_pin[m], !cpha);
        rd(3'd3, r);
        check(r[1:0] == 2'b10, "R4 word complete set", r[1:0], 2'b10);
      end
      for (int wi = 0; wi < 3; wi++) begin
        for (int li = 0; li < 3; li++) begin
          int code, n, w;
          code = (wi == 0) ? 1 : ((wi == 1) ? 3 : 7);
          w = 1 << wi;
          n = (li == 0) ? 8 : ((li == 1) ? 32 : 128);
          s_tx = {32'hA1B2_C3D4 ^ 32'(wi), 32'h0F1E_2D3C, 32'h8899_AABB + 32'(m), 32'h4C5D_6E7F ^ 32'(li * 13)};
          run_word(m, code, n, 0, 0, cnt);
          check(cnt == (n / w) * (div + 1), $sformatf("R4 read busy m%0d w%0d n%0d", m, w, n),
                cnt, (n / w) * (div + 1));
          check(s_oe_seen == 4'b0000, "R7 read drives nothing", s_oe_seen, 0);
          rd_data(d);
          check(d == (s_tx & mask_of(n)), $sformatf("R7 read data m%0d w%0d n%0d", m, w, n),
                d, s_tx & mask_of(n));
        end
      end
    end

    // R2 divider zero acts as one, mode 0 on cs1, active low
    wr(3'd1, 32'h0);
    s_cpol = 0; s_cpha = 0;
    wr(3'd0, 32'h8000_0000);
    pat = 128'h0000_0000_0000_0000_0000_0000_0000_00B6;
    wr(3'd4, pat[31:0]);
    run_word(1, 2, 8, 0, 0, cnt);
    check(cnt == 16, "R2 divider zero as one", cnt, 16);

    // R9 frame of three words
    wr(3'd0, 32'h8000_0001);
    for (int k = 0; k < 3; k++) begin
      run_word(1, 2, 8, 2, 0, cnt);
      check(cs_pin[1] == (k == 2), $sformatf("R9 frame word %0d cs", k), cs_pin[1], k == 2);
    end

    // R10 invalidate mid frame, counter reset
    run_word(1, 2, 8, 5, 0, cnt);
    check(cs_pin[1] == 1'b0, "R10 cs held before invalidate", cs_pin[1], 0);
    wr(3'd2, cmd_word(1, 4, 8, 0));
    check(cs_pin[1] == 1'b1, "R10 invalidate releases cs", cs_pin[1], 1);
    rd(3'd3, r);
    check(r[1:0] == 2'b00, "R4 word complete cleared by command", r[1:0], 0);
    run_word(1, 2, 8, 1, 0, cnt);
    check(cs_pin[1] == 1'b0, "R10 count restarted", cs_pin[1], 0);
    run_word(1, 2, 8, 1, 0, cnt);
    check(cs_pin[1] == 1'b1, "R10 new frame ends", cs_pin[1], 1);

    // R3 unsupported code ignored
    rd(3'd2, r);
    d = {96'b0, r};
    wr(3'd2, cmd_word(3, 5, 8, 0));
    rd(3'd2, r);
    check(r == d[31:0], "R3 unsupported code leaves command", r, d[31:0]);
    rd(3'd3, r);
    check(r[1:0] == 2'b10, "R3 unsupported code leaves status", r[1:0], 2'b10);
    check(cs_pin == 4'hF && sclk == 1'b0, "R3 unsupported code leaves pins", {cs_pin, sclk}, {4'hF, 1'b0});

    // R5 command during busy ignored
    wr(3'd0, 32'h8000_0003);
    pat = {96'b0, 32'hDEAD_5A3C};
    wr(3'd4, pat[31:0]);
    run_word(0, 2, 32, 0, 1, cnt);
    check(cnt == 32 * 4, "R5 timing unaffected", cnt, 128);
    check(s_rx[31:0] == pat[31:0], "R5 data unaffected", s_rx[31:0], pat[31:0]);
    rd(3'd2, r);
    check(r == cmd_word(0, 2, 32, 0), "R5 command register unchanged", r, cmd_word(0, 2, 32, 0));

    // R2 clock disabled stalls the word
    wr(3'd0, 32'h0000_0001);
    pat = {120'b0, 8'h93};
    wr(3'd4, pat[31:0]);
    s_n = 8; s_w = 1; s_shift = 0; s_samp = 0; s_lead = 0; s_rx = '0;
    wr(3'd2, cmd_word(0, 2, 8, 0));
    s_arm = 1;
    repeat (30) @(negedge clk);
    rd(3'd3, r);
    check(r[0] == 1'b1 && (s_lead + s_shift + s_samp) == 0, "R2 disabled clock stalls",
          {r[0], 32'(s_lead + s_shift + s_samp)}, {1'b1, 32'h0});
    wr(3'd0, 32'h8000_0001);
    for (int k = 0; k < 200; k++) begin
      rd(3'd3, r);
      if (!r[0]) break;
    end
    s_arm = 0;
    check(r[0] == 1'b0 && s_rx[7:0] == 8'h93, "R2 resumes after enable", {r[0], s_rx[7:0]}, {1'b0, 8'h93});

    finish_up();
  end
endmodule